// File: doc/BRIEF.md
# Pseudo-SRAM Power and Mode Sequencer

This block sits on the controller side of a pseudo-SRAM. Such a memory hides its own refresh behind an SRAM-style interface, but it must be woken in a fixed order. Once the board reports stable supply, the sequencer holds chip select high for a timed interval. It then completes start-up in one of two ways, chosen by a parameter. In the first, it borrows the access engine to issue a set of dummy reads, each framed by chip select low for one full read cycle. In the second, it waits a longer idle period with chip select high. The power-down pin stays high for the whole of start-up.

In normal operation the engine's chip select passes through to the memory, and host requests are granted. A sleep request, taken only while no access is in flight, drives the power-down pin low. After a short suspend interval the block reports deep power-down. A wake request raises the pin and replays the complete start-up. Because the array loses its contents in deep power-down, a sticky reload flag tells the host to restore memory. All delays are given in microseconds or nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: Reset or pwr_good low: mode=0 (off), mem_cs_n=1, mem_pd_n=1, ready=0, busy=0, dmy_rd=0, reload_flag=0.
- R2: In mode 0, pwr_good high moves the block to mode 1 (first wait) on the next edge. Mode 1 lasts exactly INIT_US*CLK_MHZ cycles with mem_cs_n=1.
- R3: With IDLE_START=0, the first wait is followed by NUM_DUMMY dummy reads. Each read is ceil(TRC_NS*CLK_MHZ/1000) cycles of mode 3 with mem_cs_n=0 and dmy_rd=1, then one cycle of mode 4 with mem_cs_n=1. After the last read the block enters mode 5 (run).
- R4: With IDLE_START=1, the first wait is followed by mode 2 for exactly EXTRA_US*CLK_MHZ cycles with mem_cs_n=1, then mode 5. dmy_rd never rises.
- R5: mem_pd_n is high in modes 0 to 5.
- R6: ready is high only in mode 5, and host_gnt = host_req && ready. In mode 5 mem_cs_n equals eng_cs_n; in all other modes eng_cs_n has no effect on mem_cs_n.
- R7: In mode 5, sleep_req with acc_active=0 moves the block to mode 6 (suspend): mem_pd_n=0, mem_cs_n=1, for ceil(SUSP_NS*CLK_MHZ/1000) cycles, then mode 7 (deep power-down) with mem_pd_n=0. With acc_active=1, and in every other mode, sleep_req is ignored.
- R8: In mode 7, wake_req moves the block to mode 1 with mem_pd_n=1 on the next edge and replays the full start-up of R2 to R4. wake_req is ignored in other modes.
- R9: reload_flag is set on the edge that leaves mode 7 on wake. reload_ack clears it; a set in the same cycle takes priority. pwr_good low clears it. A cold start does not set it.
- R10: pwr_good low in any mode puts the block in mode 0 on the next edge.
- R11: busy is high in modes 1, 2, 3, 4 and 6, and low in modes 0, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Memory supply is stable |
| sleep_req | input | 1 | Host asks for deep power-down |
| wake_req | input | 1 | Host asks to leave deep power-down |
| acc_active | input | 1 | Access engine has a transfer in flight |
| host_req | input | 1 | Host asks for a memory access |
| eng_cs_n | input | 1 | Access engine chip select, active low |
| reload_ack | input | 1 | Host has seen the reload flag |
| mem_cs_n | output | 1 | Chip select to the memory, active low |
| mem_pd_n | output | 1 | Power-down pin to the memory, low = deep power-down |
| dmy_rd | output | 1 | Asks the engine to drive a dummy read cycle |
| host_gnt | output | 1 | Host access granted |
| ready | output | 1 | Normal operation reached |
| busy | output | 1 | A timed sequence is running |
| mode | output | 3 | Current mode, codes as in R1 to R11 |
| reload_flag | output | 1 | Memory contents were lost and must be reloaded |

## Verification
The bench builds two instances with CLK_MHZ=1, TRC_NS=2500 and SUSP_NS=2000. This gives a 200-cycle first wait, 300-cycle extra wait, 3-cycle dummy reads and a 2-cycle suspend, so full start-ups fit in a few hundred cycles. One instance uses dummy-read start-up with two reads and is compared against a behavioural model on every clock. The other uses idle start-up; its mode-2 length and the total start-up time are measured. The same stimulus takes both instances through cold start, blocked and accepted sleep, deep power-down, wake with reload acknowledge, and a supply drop in the middle of start-up.

// File: rtl/psq_pkg.sv
package psq_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_INIT  = 3'd1,
      ST_EXTRA = 3'd2,
      ST_RDLO  = 3'd3,
      ST_RDGAP = 3'd4,
      ST_RUN   = 3'd5,
      ST_SUSP  = 3'd6,
      ST_DPD   = 3'd7
   } psq_state_e;

   // rounds up and never returns zero
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
      int unsigned c;
      c = (ns * mhz + 999) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/psq_rdcnt.sv
module psq_rdcnt #(
   parameter int NUM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic reached
);
   localparam int CW = $clog2(NUM + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign reached = (cnt >= CW'(NUM));
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psq_pkg::*;
#(
   parameter int unsigned CLK_MHZ    = 50,
   parameter int unsigned INIT_US    = 200,
   parameter int unsigned EXTRA_US   = 300,
   parameter int unsigned SUSP_NS    = 500,
   parameter int unsigned TRC_NS     = 70,
   parameter int unsigned NUM_DUMMY  = 2,
   parameter bit          IDLE_START = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic       acc_active,
   input  logic       host_req,
   input  logic       eng_cs_n,
   input  logic       reload_ack,
   output logic       mem_cs_n,
   output logic       mem_pd_n,
   output logic       dmy_rd,
   output logic       host_gnt,
   output logic       ready,
   output logic       busy,
   output logic [2:0] mode,
   output logic       reload_flag
);
   localparam int unsigned INIT_CYC  = INIT_US * CLK_MHZ;
   localparam int unsigned EXTRA_CYC = EXTRA_US * CLK_MHZ;
   localparam int unsigned SUSP_CYC  = ns_to_cyc(SUSP_NS, CLK_MHZ);
   localparam int unsigned TRC_CYC   = ns_to_cyc(TRC_NS, CLK_MHZ);
   localparam int unsigned MAX_A     = (INIT_CYC > EXTRA_CYC) ? INIT_CYC : EXTRA_CYC;
   localparam int unsigned MAX_B     = (SUSP_CYC > TRC_CYC) ? SUSP_CYC : TRC_CYC;
   localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int          TW        = $clog2(MAX_CYC + 1);
   localparam logic [TW-1:0] INIT_LD  = TW'(INIT_CYC - 1);
   localparam logic [TW-1:0] EXTRA_LD = TW'(EXTRA_CYC - 1);
   localparam logic [TW-1:0] SUSP_LD  = TW'(SUSP_CYC - 1);
   localparam logic [TW-1:0] TRC_LD   = TW'(TRC_CYC - 1);
   localparam logic [TW-1:0] POST_LD  = IDLE_START ? EXTRA_LD : TRC_LD;

   // elaboration-time parameter checks
   if (CLK_MHZ == 0)   begin : g_bad_clk   $error("CLK_MHZ must be nonzero");   end
   if (INIT_US == 0)   begin : g_bad_init  $error("INIT_US must be nonzero");   end
   if (EXTRA_US == 0)  begin : g_bad_extra $error("EXTRA_US must be nonzero");  end
   if (NUM_DUMMY < 2)  begin : g_bad_num   $error("NUM_DUMMY must be at least 2"); end

   psq_state_e st, nxt, after_init;
   logic          ld, t_done, rd_clr, rd_inc, rd_reached, wake_ev;
   logic [TW-1:0] ld_val;

   // start-up variant picks the state that follows the first wait
   if (IDLE_START) begin : g_idle
      assign after_init = ST_EXTRA;
   end else begin : g_dummy
      assign after_init = ST_RDLO;
   end

   psq_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .done(t_done)
   );

   psq_rdcnt #(.NUM(NUM_DUMMY)) u_rdcnt (
      .clk(clk), .rst_n(rst_n), .clr(rd_clr), .inc(rd_inc), .reached(rd_reached)
   );

   always_comb begin
      nxt     = st;
      ld      = 1'b0;
      ld_val  = '0;
      rd_clr  = 1'b0;
      rd_inc  = 1'b0;
      wake_ev = 1'b0;
      if (!pwr_good) begin
         nxt = ST_OFF;
      end else begin
         case (st)
            ST_OFF: begin
               nxt = ST_INIT; ld = 1'b1; ld_val = INIT_LD;
            end
            ST_INIT: if (t_done) begin
               nxt = after_init; ld = 1'b1; ld_val = POST_LD; rd_clr = 1'b1;
            end
            ST_EXTRA: if (t_done) nxt = ST_RUN;
            ST_RDLO: if (t_done) begin
               nxt = ST_RDGAP; rd_inc = 1'b1;
            end
            ST_RDGAP: begin
               if (rd_reached) nxt = ST_RUN;
               else begin
                  nxt = ST_RDLO; ld = 1'b1; ld_val = TRC_LD;
               end
            end
            ST_RUN: if (sleep_req && !acc_active) begin
               nxt = ST_SUSP; ld = 1'b1; ld_val = SUSP_LD;
            end
            ST_SUSP: if (t_done) nxt = ST_DPD;
            ST_DPD: if (wake_req) begin
               nxt = ST_INIT; ld = 1'b1; ld_val = INIT_LD; wake_ev = 1'b1;
            end
            default: nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reload_flag <= 1'b0;
      else if (!pwr_good)  reload_flag <= 1'b0;
      else if (wake_ev)    reload_flag <= 1'b1;
      else if (reload_ack) reload_flag <= 1'b0;
   end

   assign mode     = st;
   assign ready    = (st == ST_RUN);
   assign dmy_rd   = (st == ST_RDLO);
   assign mem_cs_n = ready ? eng_cs_n : !dmy_rd;
   assign mem_pd_n = !((st == ST_SUSP) || (st == ST_DPD));
   assign busy     = (st == ST_INIT) || (st == ST_EXTRA) || (st == ST_RDLO) ||
                     (st == ST_RDGAP) || (st == ST_SUSP);
   assign host_gnt = host_req && ready;
endmodule

// File: rtl/psq_chk.sv
module psq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_good,
   input logic       sleep_req,
   input logic       wake_req,
   input logic       acc_active,
   input logic       host_req,
   input logic       mem_cs_n,
   input logic       mem_pd_n,
   input logic       dmy_rd,
   input logic       host_gnt,
   input logic       ready,
   input logic [2:0] mode,
   input logic       reload_flag
);
   p_off_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (mode == 3'd0 && mem_pd_n && mem_cs_n));

   p_init_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 && pwr_good) |=> (mode == 3'd1 && mem_cs_n));

   p_sleep_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 && acc_active && pwr_good) |=> (mode == 3'd5));

   p_sleep_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 && sleep_req && !acc_active && pwr_good) |=> (mode == 3'd6 && !mem_pd_n));

   p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd7 && wake_req && pwr_good) |=> (mode == 3'd1 && mem_pd_n && reload_flag));

   p_gnt_only_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt |-> (ready && host_req)));

   p_cs_low_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !ready) |-> dmy_rd);

   p_dpd_after_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd6 && pwr_good) |=> (mode == 3'd6 || mode == 3'd7));
endmodule

bind psram_pwr_seq psq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
   .wake_req(wake_req), .acc_active(acc_active), .host_req(host_req),
   .mem_cs_n(mem_cs_n), .mem_pd_n(mem_pd_n), .dmy_rd(dmy_rd), .host_gnt(host_gnt),
   .ready(ready), .mode(mode), .reload_flag(reload_flag)
);

// File: tb/sim_psram_pwr_seq.sv
module sim_psram_pwr_seq;
   localparam int INIT_C  = 200;
   localparam int EXTRA_C = 300;
   localparam int TRC_C   = 3;
   localparam int SUSP_C  = 2;
   localparam int NUMD    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, acc_active = 1'b0;
   logic host_req = 1'b0, eng_cs_n = 1'b1, reload_ack = 1'b0;

   logic cs0, pd0, dr0, gnt0, rdy0, busy0, fl0;
   logic [2:0] md0;
   logic cs1, pd1, dr1, gnt1, rdy1, busy1, fl1;
   logic [2:0] md1;

   int errors = 0, checks = 0, cyc = 0;

   always #10 clk = ~clk;

   psram_pwr_seq #(.CLK_MHZ(1), .TRC_NS(2500), .SUSP_NS(2000), .NUM_DUMMY(NUMD),
                   .IDLE_START(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
      .wake_req(wake_req), .acc_active(acc_active), .host_req(host_req),
      .eng_cs_n(eng_cs_n), .reload_ack(reload_ack), .mem_cs_n(cs0), .mem_pd_n(pd0),
      .dmy_rd(dr0), .host_gnt(gnt0), .ready(rdy0), .busy(busy0), .mode(md0),
      .reload_flag(fl0));

   psram_pwr_seq #(.CLK_MHZ(1), .TRC_NS(2500), .SUSP_NS(2000), .NUM_DUMMY(NUMD),
                   .IDLE_START(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
      .wake_req(wake_req), .acc_active(acc_active), .host_req(host_req),
      .eng_cs_n(eng_cs_n), .reload_ack(reload_ack), .mem_cs_n(cs1), .mem_pd_n(pd1),
      .dmy_rd(dr1), .host_gnt(gnt1), .ready(rdy1), .busy(busy1), .mode(md1),
      .reload_flag(fl1));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // behavioural reference for u0: phase, cycles left, reads done, flag
   int m_st = 0, m_rem = 0, m_rd = 0;
   bit m_fl = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_rd = 0; m_fl = 0;
      end else if (!pwr_good) begin
         m_st = 0; m_fl = 0;
      end else begin
         bit woke;
         woke = 0;
         case (m_st)
            0: begin m_st = 1; m_rem = INIT_C; end
            1: begin m_rem--; if (m_rem == 0) begin m_st = 3; m_rem = TRC_C; m_rd = 0; end end
            3: begin m_rem--; if (m_rem == 0) begin m_rd++; m_st = 4; end end
            4: begin if (m_rd >= NUMD) m_st = 5; else begin m_st = 3; m_rem = TRC_C; end end
            5: if (sleep_req && !acc_active) begin m_st = 6; m_rem = SUSP_C; end
            6: begin m_rem--; if (m_rem == 0) m_st = 7; end
            7: if (wake_req) begin m_st = 1; m_rem = INIT_C; woke = 1; end
            default: m_st = 0;
         endcase
         if (woke) m_fl = 1;
         else if (reload_ack) m_fl = 0;
      end
   end

   function automatic string tag_of(input int s);
      case (s)
         0: return "R1";
         1: return "R2";
         3, 4: return "R3";
         5: return "R6";
         default: return "R7";
      endcase
   endfunction

   // u1 start-up timing monitor
   int u1_tot = 0, u1_m2 = 0, u1_seen_rd = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         string t;
         t = tag_of(m_st);
         chk(t, "mode", md0, m_st);
         chk(t, "mem_cs_n", cs0, (m_st == 5) ? eng_cs_n : (m_st != 3));
         chk("R5", "mem_pd_n", pd0, !(m_st == 6 || m_st == 7));
         chk("R3", "dmy_rd", dr0, m_st == 3);
         chk("R6", "ready", rdy0, m_st == 5);
         chk("R6", "host_gnt", gnt0, host_req && m_st == 5);
         chk("R11", "busy", busy0, m_st == 1 || m_st == 2 || m_st == 3 || m_st == 4 || m_st == 6);
         chk("R9", "reload_flag", fl0, m_fl);
         if (dr1) u1_seen_rd = 1;
         if (md1 == 3'd0) begin u1_tot = 0; u1_m2 = 0; end
         if (md1 == 3'd1 || md1 == 3'd2) u1_tot++;
         if (md1 == 3'd2) u1_m2++;
         if (md1 == 3'd5 && u1_tot != 0) begin
            chk("R4", "idle start-up total cycles", u1_tot, INIT_C + EXTRA_C);
            chk("R4", "mode 2 length", u1_m2, EXTRA_C);
            u1_tot = 0; u1_m2 = 0;
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         summary();
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      step(3);
      @(negedge clk);
      chk("R1", "reset mode", md0, 0);
      chk("R1", "reset cs", cs0, 1);
      chk("R1", "reset busy", busy0, 0);
      rst_n = 1'b1;
      step(4);
      chk("R1", "off with supply low", md0, 0);
      // cold start; noise on eng/sleep/wake during start-up must be ignored
      pwr_good = 1'b1;
      eng_cs_n = 1'b0; sleep_req = 1'b1; wake_req = 1'b1; host_req = 1'b1;
      step(1);
      @(negedge clk);
      chk("R2", "first wait entered", md0, 1);
      step(100);
      sleep_req = 1'b0; wake_req = 1'b0;
      step(500);
      chk("R4", "idle variant reached run", md1, 5);
      chk("R4", "idle variant never drove dummy read", u1_seen_rd, 0);
      chk("R9", "no reload flag after cold start", fl0, 0);
      // run mode traffic
      for (int i = 0; i < 8; i++) begin
         eng_cs_n = i[0]; host_req = i[1];
         step(1);
      end
      // sleep blocked by an access in flight
      acc_active = 1'b1; sleep_req = 1'b1;
      step(5);
      chk("R7", "sleep refused during access", md0, 5);
      acc_active = 1'b0;
      step(1);
      sleep_req = 1'b0;
      step(SUSP_C + 1);
      @(negedge clk);
      chk("R7", "deep power-down reached", md0, 7);
      chk("R7", "pd pin low", pd0, 0);
      // engine activity in deep power-down has no effect
      for (int i = 0; i < 6; i++) begin
         eng_cs_n = i[0]; host_req = 1'b1;
         step(1);
      end
      host_req = 1'b0;
      wake_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      @(negedge clk);
      chk("R8", "wake returns to first wait", md0, 1);
      chk("R8", "pd pin high after wake", pd0, 1);
      chk("R9", "reload flag set on wake", fl0, 1);
      step(600);
      chk("R8", "run reached after wake", md0, 5);
      chk("R9", "flag held until ack", fl0, 1);
      reload_ack = 1'b1;
      step(1);
      reload_ack = 1'b0;
      @(negedge clk);
      chk("R9", "flag cleared by ack", fl0, 0);
      // sleep, wake, then a supply drop during start-up
      sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
      step(SUSP_C + 3);
      wake_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      step(50);
      pwr_good = 1'b0;
      step(1);
      @(negedge clk);
      chk("R10", "supply drop forces off", md0, 0);
      chk("R10", "supply drop forces off (idle variant)", md1, 0);
      chk("R9", "flag cleared by supply drop", fl0, 0);
      step(5);
      pwr_good = 1'b1;
      step(INIT_C + 2);
      @(negedge clk);
      chk("R3", "dummy read in progress", md0, 3);
      step(600);
      chk("R3", "run after second cold start", md0, 5);
      summary();
      $finish;
   end
endmodule